// File: doc/BRIEF.md
# Modulation-Order Row-Column Bit Interleaver

This block takes a serial stream of coded bits, one codeword of E bits at a time, and reorders it for a modulator that groups Qm bits per symbol. Each codeword fills a matrix of Qm columns row by row, in arrival order. The block then emits the same E bits column by column. The matrix has ceil(E/Qm) rows. When E is not a multiple of Qm, the last row is only partly filled, and its empty cells are passed over on readout rather than sent as padding.

Storage has two banks that take turns. One codeword can stream in while the one before it streams out, so a steady producer and consumer see no gap between codewords. The length and the modulation order are sampled on the first bit of each codeword and stay with that codeword's bank until it has been read out. Both the input and the output use a valid/ready handshake, and the output marks the final bit of each codeword.

Top module: `rmi_interleaver`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Input bit i of a codeword (counting from 0) occupies row i/Qm, column i%Qm. The output sends column 0 from the top row down, then column 1, and so on up to column Qm-1.
- R3: Exactly E bits are output per codeword. Cells with index r*Qm+c >= E in a partial last row are skipped with no dead cycles, and `out_valid` drops once the E bits are gone when no other codeword is stored.
- R4: `out_last` is 1 on the E-th output bit of a codeword and 0 on every other output bit.
- R5: `cfg_qm` carries the column count as a plain binary value, one of 1, 2, 4, 6 or 8. With Qm=1, the output order equals the input order.
- R6: `cfg_len` and `cfg_qm` are sampled on the accepted first bit of a codeword. Changes to them while later bits of that codeword are accepted have no effect on its length or order.
- R7: Two complete codewords can be accepted while none is read. `in_ready` is then 0 until the older codeword has been fully output, and it returns to 1 after that.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_bit` and `out_last` hold their values.
- R9: E ranges from 1 up to the parameter E_MAX (default 8192). Both extremes produce the order of R2.
- R10: Bits offered on `in_valid` while `in_ready` is 0 are not accepted and do not appear in any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | EW ($clog2(E_MAX+1)) | Codeword length E, sampled on its first bit |
| cfg_qm | input | 4 | Modulation order Qm (1, 2, 4, 6 or 8), sampled on the first bit |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Block can accept an input bit |
| in_bit | input | 1 | Input bit |
| out_valid | output | 1 | Output bit available |
| out_ready | input | 1 | Consumer takes the output bit |
| out_bit | output | 1 | Interleaved output bit |
| out_last | output | 1 | Final bit of the codeword |

## Verification
Each codeword carries a position-dependent pseudo-random pattern, so any bit sent from the wrong matrix cell gives a mismatch. The pattern is checked against the column-major order for several shapes: a full matrix (E=12, Qm=4), partial last rows (E=100 with Qm=6, and E=33 with Qm=2), fewer bits than columns (E=7, Qm=8), a single column, E=1, and E=E_MAX. Together these separate a correct row and column walk from one that pads, drops cells or mixes up row and column. Further scenarios cover the remaining behaviour: configuration changed in the middle of a codeword, two banks filled with no reads in between (plus junk offered while stalled), and output back-pressure. These show that the banks alternate correctly and that settings are captured once per codeword.

// File: rtl/rmi_pkg.sv
// Package: shared types and helpers for the row-column interleaver.
// Assumes the column count never exceeds 8, so it fits in four bits.
package rmi_pkg;

    localparam int unsigned RMI_NBANK = 2;

    // Column count (modulation order) carried as a plain binary value.
    typedef logic [3:0] qm_t;

    // True for the supported modulation orders.
    function automatic logic qm_legal(input qm_t q);
        return (q == 4'd1) || (q == 4'd2) || (q == 4'd4) ||
               (q == 4'd6) || (q == 4'd8);
    endfunction

endpackage

// File: rtl/rmi_wr_ctrl.sv
// Write side: counts the bits of each codeword into the current write bank
// in row-major order (the address is simply the arrival index), captures
// the length on the first bit and switches banks when a codeword completes.
// Assumes the length is between 1 and E_MAX.
module rmi_wr_ctrl
    import rmi_pkg::*;
#(
    parameter int unsigned E_MAX = 8192,
    localparam int unsigned EW   = $clog2(E_MAX + 1),
    localparam int unsigned AW   = $clog2(E_MAX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [EW-1:0]        cfg_len,
    input  logic [RMI_NBANK-1:0] bank_full,
    output logic                 in_ready,
    output logic                 wr_en,
    output logic                 wr_bank,
    output logic [AW-1:0]        wr_addr,
    output logic                 cfg_take,
    output logic                 wr_done
);

    logic [EW-1:0] cnt_q;
    logic [EW-1:0] len_q;
    logic [EW-1:0] cur_len;
    logic          bank_q;

    // Purpose: decide acceptance and detect the last bit of the codeword.
    always_comb begin
        in_ready = !bank_full[bank_q];
        wr_en    = in_valid && in_ready;
        cur_len  = (cnt_q == '0) ? cfg_len : len_q;
        cfg_take = wr_en && (cnt_q == '0);
        wr_done  = wr_en && (cnt_q == cur_len - EW'(1));
        wr_bank  = bank_q;
        wr_addr  = cnt_q[AW-1:0];
    end

    // Purpose: advance the bit counter and toggle banks per codeword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            len_q  <= '0;
            bank_q <= 1'b0;
        end else if (wr_en) begin
            if (cnt_q == '0) len_q <= cfg_len;
            if (wr_done) begin
                cnt_q  <= '0;
                bank_q <= ~bank_q;
            end else begin
                cnt_q <= cnt_q + EW'(1);
            end
        end
    end

    // R6
    len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> $stable(len_q));

    // R7
    no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&bank_full) |-> !in_ready);

endmodule

// File: rtl/rmi_store.sv
// Two banks of bit storage, each a packed vector of E_MAX bits, plus the
// length and column count captured for the codeword each bank holds.
// Assumes the control logic never writes a bank while it is being read.
module rmi_store
    import rmi_pkg::*;
#(
    parameter int unsigned E_MAX = 8192,
    localparam int unsigned EW   = $clog2(E_MAX + 1),
    localparam int unsigned AW   = $clog2(E_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic          cfg_take,
    input  logic [EW-1:0] cfg_len,
    input  qm_t           cfg_qm,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit,
    output logic [EW-1:0] rd_len,
    output qm_t           rd_qm
);

    logic [E_MAX-1:0] mem_q [RMI_NBANK];
    logic [EW-1:0]    len_q [RMI_NBANK];
    qm_t              qm_q  [RMI_NBANK];

    for (genvar b = 0; b < RMI_NBANK; b++) begin : g_bank
        // Purpose: store one incoming bit at its row-major address.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) mem_q[b][wr_addr] <= wr_bit;
        end

        // Purpose: keep the shape of the codeword held in this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_q[b] <= EW'(1);
                qm_q[b]  <= 4'd1;
            end else if (cfg_take && (wr_bank == 1'(b))) begin
                len_q[b] <= cfg_len;
                qm_q[b]  <= cfg_qm;
            end
        end
    end

    // Purpose: select the bit and shape of the bank being read.
    always_comb begin
        rd_bit = mem_q[rd_bank][rd_addr];
        rd_len = len_q[rd_bank];
        rd_qm  = qm_q[rd_bank];
    end

endmodule

// File: rtl/rmi_rd_ctrl.sv
// Read side: walks the full bank column by column. Within a column the
// address steps by Qm; once it passes the length, the walk moves to the top
// of the next column. Cells of a partial last row are never visited.
// Assumes the stored shape is legal and the bank is full while read.
module rmi_rd_ctrl
    import rmi_pkg::*;
#(
    parameter int unsigned E_MAX = 8192,
    localparam int unsigned EW   = $clog2(E_MAX + 1),
    localparam int unsigned AW   = $clog2(E_MAX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RMI_NBANK-1:0] bank_full,
    input  logic [EW-1:0]        rd_len,
    input  qm_t                  rd_qm,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic                 out_last,
    output logic                 rd_bank,
    output logic [AW-1:0]        rd_addr,
    output logic                 rd_release
);

    logic [EW-1:0] addr_q;
    logic [EW-1:0] cnt_q;
    qm_t           col_q;
    logic          bank_q;
    logic          take;
    logic          at_end;
    logic [EW:0]   step;

    // Purpose: present the current cell and compute the next row address.
    always_comb begin
        out_valid  = bank_full[bank_q];
        at_end     = (cnt_q == rd_len - EW'(1));
        out_last   = out_valid && at_end;
        take       = out_valid && out_ready;
        rd_release = take && at_end;
        step       = {1'b0, addr_q} + (EW + 1)'(rd_qm);
        rd_bank    = bank_q;
        rd_addr    = addr_q[AW-1:0];
    end

    // Purpose: advance row, column and count on each accepted output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            col_q  <= '0;
            bank_q <= 1'b0;
        end else if (take) begin
            if (at_end) begin
                addr_q <= '0;
                cnt_q  <= '0;
                col_q  <= '0;
                bank_q <= ~bank_q;
            end else begin
                cnt_q <= cnt_q + EW'(1);
                if (step >= {1'b0, rd_len}) begin
                    col_q  <= col_q + 4'd1;
                    addr_q <= EW'(col_q + 4'd1);
                end else begin
                    addr_q <= step[EW-1:0];
                end
            end
        end
    end

    // R3
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (addr_q < rd_len));

    // R2
    col_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (col_q < rd_qm));

    // R5
    qm_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> qm_legal(rd_qm));

endmodule

// File: rtl/rmi_interleaver.sv
// Top: row-column bit interleaver with two alternating banks. The writer
// fills one bank while the reader drains the other. A bank is marked full
// when its last bit is written and free again after its last bit is read.
// Assumes 1 <= cfg_len <= E_MAX and a legal cfg_qm on each first bit.
module rmi_interleaver
    import rmi_pkg::*;
#(
    parameter int unsigned E_MAX = 8192,
    localparam int unsigned EW   = $clog2(E_MAX + 1),
    localparam int unsigned AW   = $clog2(E_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] cfg_len,
    input  logic [3:0]    cfg_qm,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_bit,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_bit,
    output logic          out_last
);

    logic [RMI_NBANK-1:0] full_q;
    logic                 wr_en;
    logic                 wr_bank;
    logic [AW-1:0]        wr_addr;
    logic                 cfg_take;
    logic                 wr_done;
    logic                 rd_bank;
    logic [AW-1:0]        rd_addr;
    logic                 rd_release;
    logic [EW-1:0]        rd_len;
    qm_t                  rd_qm;

    rmi_wr_ctrl #(.E_MAX(E_MAX)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cfg_len   (cfg_len),
        .bank_full (full_q),
        .in_ready  (in_ready),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_addr   (wr_addr),
        .cfg_take  (cfg_take),
        .wr_done   (wr_done)
    );

    rmi_store #(.E_MAX(E_MAX)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_addr  (wr_addr),
        .wr_bit   (in_bit),
        .cfg_take (cfg_take),
        .cfg_len  (cfg_len),
        .cfg_qm   (cfg_qm),
        .rd_bank  (rd_bank),
        .rd_addr  (rd_addr),
        .rd_bit   (out_bit),
        .rd_len   (rd_len),
        .rd_qm    (rd_qm)
    );

    rmi_rd_ctrl #(.E_MAX(E_MAX)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_full  (full_q),
        .rd_len     (rd_len),
        .rd_qm      (rd_qm),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .rd_bank    (rd_bank),
        .rd_addr    (rd_addr),
        .rd_release (rd_release)
    );

    // Purpose: track which banks hold a complete, unread codeword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
        end else begin
            for (int b = 0; b < RMI_NBANK; b++) begin
                if (wr_done && (wr_bank == 1'(b)))         full_q[b] <= 1'b1;
                else if (rd_release && (rd_bank == 1'(b))) full_q[b] <= 1'b0;
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_bit) && $stable(out_last)));

    // R7
    bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (wr_bank != $past(wr_bank)));

endmodule

// File: tb/tb_rmi_interleaver.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_rmi_interleaver;

    localparam int unsigned E_MAX = 8192;
    localparam int unsigned EW    = $clog2(E_MAX + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [EW-1:0] cfg_len = '0;
    logic [3:0]    cfg_qm = 4'd1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_bit = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic          out_bit;
    logic          out_last;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rmi_interleaver #(.E_MAX(E_MAX)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_len   (cfg_len),
        .cfg_qm    (cfg_qm),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    // Pseudo-random bit for position i of codeword seed.
    function automatic logic pat(input int seed, input int i);
        logic [31:0] h;
        h = 32'(i) * 32'h9E3779B1 + 32'(seed) * 32'h85EBCA6B;
        h = h ^ (h >> 15);
        return h[7] ^ h[3];
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stream one codeword in; alt alters the config after the first bit.
    task automatic send_word(input int e, input int q, input int seed, input bit alt);
        for (int i = 0; i < e; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_bit   = pat(seed, i);
            cfg_len  = (alt && i > 0) ? EW'(3) : EW'(e);
            cfg_qm   = (alt && i > 0) ? 4'((q == 2) ? 4 : 2) : 4'(q);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Drain one codeword and compare against the column-major order.
    task automatic recv_word(input int e, input int q, input int seed,
                             input bit idle, input string req);
        int k = 0;
        int bad = 0;
        int bad_last = 0;
        int first_idx = -1;
        int first_act = 0;
        for (int c = 0; c < q; c++) begin
            for (int r = 0; r * q + c < e; r++) begin
                @(negedge clk);
                out_ready = 1'b1;
                while (!out_valid) @(negedge clk);
                if (out_bit !== pat(seed, r * q + c)) begin
                    bad++;
                    if (first_idx < 0) begin
                        first_idx = k;
                        first_act = int'(out_bit);
                    end
                end
                if (out_last !== (k == e - 1)) bad_last++;
                @(posedge clk);
                k++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(bad == 0, {req, " order (R2)"}, bad, 0);
        chk(bad_last == 0, {req, " last flag R4"}, bad_last, 0);
        if (idle) chk(!out_valid, {req, " no padding R3"}, int'(out_valid), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    endtask

    task automatic t_shape(input int e, input int q, input int seed, input string req);
        send_word(e, q, seed, 1'b0);
        recv_word(e, q, seed, 1'b1, req);
    endtask

    // R6: config wiggles after the first bit must not matter.
    task automatic t_cfg_change();
        send_word(40, 6, 77, 1'b1);
        recv_word(40, 6, 77, 1'b1, "R6 cfg change");
    endtask

    // R7 and R10: fill both banks, offer junk while stalled, drain.
    task automatic t_double();
        send_word(50, 4, 11, 1'b0);
        send_word(37, 6, 12, 1'b0);
        @(negedge clk);
        chk(in_ready === 1'b0, "R7 both full", int'(in_ready), 0);
        in_valid = 1'b1;
        for (int j = 0; j < 5; j++) begin
            in_bit = j[0];
            @(negedge clk);
        end
        chk(in_ready === 1'b0, "R10 stalled", int'(in_ready), 0);
        in_valid = 1'b0;
        recv_word(50, 4, 11, 1'b0, "R7 first");
        chk(in_ready === 1'b1, "R7 freed", int'(in_ready), 1);
        recv_word(37, 6, 12, 1'b1, "R10 second");
        send_word(21, 8, 13, 1'b0);
        recv_word(21, 8, 13, 1'b1, "R7 third");
    endtask

    // R8: hold off the consumer and watch the output freeze.
    task automatic t_stall();
        logic b0;
        logic l0;
        int moved = 0;
        send_word(10, 2, 21, 1'b0);
        @(negedge clk);
        b0 = out_bit;
        l0 = out_last;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            if (!out_valid || out_bit !== b0 || out_last !== l0) moved++;
        end
        chk(moved == 0, "R8 hold", moved, 0);
        recv_word(10, 2, 21, 1'b1, "R8 after stall");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_shape(12, 4, 1, "R2 full matrix");
        t_shape(100, 6, 2, "R3 partial row");
        t_shape(7, 8, 3, "R3 narrow");
        t_shape(33, 2, 4, "R3 odd");
        t_shape(20, 1, 5, "R5 single column");
        t_shape(1, 2, 6, "R9 min length");
        t_cfg_change();
        t_double();
        t_stall();
        t_shape(int'(E_MAX), 8, 7, "R9 max length");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule